// File: doc/BRIEF.md
# Serial Quad DAC Command Front End

This block is the digital front end of a four-channel, 16-bit digital-to-analog converter. A host sends 32-bit frames over a three-wire link: an active-low frame sync, a serial clock and a data line. The block oversamples all three with its own system clock. It collects the frame on falling serial-clock edges and decodes a command nibble and an address nibble. It then updates a set of per-channel registers. Each channel has a staging (input) register and an active (DAC) register. Commands can stage a code, apply staged codes, or do both in one frame. Further commands set channel power state, choose a clear code, program a mask that lets chosen channels apply their codes at once, or return everything to its reset state.

Two active-low pins act on the registers directly. The update pin applies staged codes on every channel whose mask bit is clear. The clear pin forces every active register to the selected clear code. The outputs are the four active codes, which drive the converter cores, and the four power-down flags. Every serial and pin input passes through a two-stage synchronizer before use.

Top module: `qdacFrontEnd`

## Requirements
- R1: A frame holds 32 bits, most significant first, sampled on falling serial-clock edges while frame sync is low. Frame bits 31:28 and 3:0 are ignored. Bits 27:24 are the command, bits 23:20 the address and bits 19:4 the 16-bit code. The command takes effect only after the 32nd falling edge, and falling edges after the 32nd do nothing.
- R2: If frame sync returns high before the 32nd falling edge, the partial frame is dropped and no register or output changes.
- R3: Command 0x0 loads the code into the staging register of each addressed channel. The active register of a channel changes only if that channel's mask bit is 1.
- R4: Command 0x1 copies the staging register of each addressed channel into its active register.
- R5: Command 0x2 loads the code into the staging register of each addressed channel, then copies all four staging registers into the active registers.
- R6: Command 0x3 loads the code into both the staging and the active register of each addressed channel.
- R7: Addresses 0x0 to 0x3 select channels A to D, and 0xF selects all four channels. For commands 0x0 to 0x3, an address from 0x4 to 0xE makes the whole frame a no-op. Commands 0x8 to 0xF are no-ops. Commands 0x4 to 0x7 ignore the address.
- R8: Command 0x4 changes the power flag of each channel i whose code bit i is 1. The new flag value is code bit 4, where 1 means powered down. The active and staging codes are not affected.
- R9: Command 0x5 sets the clear code from code bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 keeps the current selection. While the clear pin is low, every active register holds the clear code. Staging registers are not affected.
- R10: Command 0x6 loads the mask from code bits 3:0, with bit i for channel i. While the update pin is low, every channel with mask bit 0 copies its staging register into its active register. Channels with mask bit 1 ignore the pin.
- R11: After hardware reset, and after command 0x7, all staging and active codes are 0x0000, all channels are powered up, the mask is 0 and the clear code is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link and pins |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSyncN | input | 1 | Active-low frame enclosure |
| serialClk | input | 1 | Serial clock; data is taken on its falling edge |
| serialDin | input | 1 | Serial data, most significant bit first |
| updateN | input | 1 | Active-low apply of staged codes for unmasked channels |
| clearN | input | 1 | Active-low force of the clear code into all active registers |
| dacCodes | output | 64 | Active codes; channel A in bits 15:0, channel D in bits 63:48 |
| powerDown | output | 4 | Per-channel power-down flags; bit i belongs to channel i |

## Verification
The checker assumes that each serial-clock phase lasts several system clocks, so no serial edge is lost in the synchronizers. It also assumes that frame sync, the data line and the two pins change only while the serial clock is high or idle. The checker relates the decoded strobes to the outputs one cycle later, so it relies on the synchronizers, not the host, to make strobes clean. The bench drives each serial-clock phase for four system clocks. It changes data only during the high phase and holds each pin pulse for six clocks, which keeps all stimulus inside these assumptions.

// File: rtl/qdacPkg.sv
package qdacPkg;
  parameter int unsigned CH_COUNT   = 4;
  parameter int unsigned CODE_BITS  = 16;
  parameter int unsigned FRAME_BITS = 32;
  parameter int unsigned HEAD_PAD   = 4;
  parameter int unsigned TAIL_PAD   = 4;
  parameter int unsigned NIB        = 4;

  // bits that carry command, address and code
  localparam int unsigned KEEP_BITS = FRAME_BITS - HEAD_PAD - TAIL_PAD;

  localparam logic [NIB-1:0] CMD_WR_IN      = 4'h0;
  localparam logic [NIB-1:0] CMD_APPLY      = 4'h1;
  localparam logic [NIB-1:0] CMD_WR_UPD_ALL = 4'h2;
  localparam logic [NIB-1:0] CMD_WR_UPD_ONE = 4'h3;
  localparam logic [NIB-1:0] CMD_POWER      = 4'h4;
  localparam logic [NIB-1:0] CMD_CLR_CODE   = 4'h5;
  localparam logic [NIB-1:0] CMD_MASK       = 4'h6;
  localparam logic [NIB-1:0] CMD_RESET      = 4'h7;
  localparam logic [NIB-1:0] ADDR_ALL       = '1;

  // strobes from control to datapath; all zero when nothing happens
  typedef struct packed {
    logic [CH_COUNT-1:0]  wrInput;
    logic [CH_COUNT-1:0]  updDac;
    logic                 pdLoad;
    logic                 clrLoad;
    logic                 maskLoad;
    logic                 softReset;
    logic                 hwUpdate;
    logic                 hwClear;
    logic [CODE_BITS-1:0] data;
  } strobeT;
endpackage

// File: rtl/qdacLink.sv
module qdacLink
  import qdacPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameSyncN,
  input  logic   serialClk,
  input  logic   serialDin,
  input  logic   updateN,
  input  logic   clearN,
  output strobeT strb
);
  localparam int unsigned LINES = 5;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CAP_LO   = CNT_W'(HEAD_PAD);
  localparam logic [CNT_W-1:0] CAP_HI   = CNT_W'(FRAME_BITS - TAIL_PAD);

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncOut;

  assign rawIn = {frameSyncN, serialClk, serialDin, updateN, clearN};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipeQ <= '1;
      else       pipeQ <= {pipeQ[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipeQ[SYNC_STAGES-1];
  end

  logic fsS, sclkS, dinS, updS, clrS;
  assign {fsS, sclkS, dinS, updS, clrS} = syncOut;

  logic                 sclkPrev;
  logic                 fallEdge;
  logic [CNT_W-1:0]     bitCnt;
  logic [KEEP_BITS-1:0] capReg;
  logic                 frameValid;

  assign fallEdge = sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev   <= 1'b1;
      bitCnt     <= '0;
      capReg     <= '0;
      frameValid <= 1'b0;
    end else begin
      sclkPrev   <= sclkS;
      frameValid <= 1'b0;
      if (fsS) begin
        bitCnt <= '0;
      end else if (fallEdge && bitCnt < CNT_FULL) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt >= CAP_LO && bitCnt < CAP_HI)
          capReg <= {capReg[KEEP_BITS-2:0], dinS};
        if (bitCnt == CNT_LAST)
          frameValid <= 1'b1;
      end
    end
  end

  logic [NIB-1:0]       cmdNib;
  logic [NIB-1:0]       addrNib;
  logic [CH_COUNT-1:0]  chanSel;
  logic                 addrOk;

  assign cmdNib  = capReg[KEEP_BITS-1 -: NIB];
  assign addrNib = capReg[KEEP_BITS-NIB-1 -: NIB];

  always_comb begin
    for (int i = 0; i < CH_COUNT; i++)
      chanSel[i] = (addrNib == NIB'(i)) || (addrNib == ADDR_ALL);
  end
  assign addrOk = |chanSel;

  always_comb begin
    strb          = '0;
    strb.hwUpdate = ~updS;
    strb.hwClear  = ~clrS;
    if (frameValid) begin
      strb.data = capReg[CODE_BITS-1:0];
      case (cmdNib)
        CMD_WR_IN:      strb.wrInput = chanSel;
        CMD_APPLY:      strb.updDac  = chanSel;
        CMD_WR_UPD_ALL: begin
          strb.wrInput = chanSel;
          strb.updDac  = addrOk ? '1 : '0;
        end
        CMD_WR_UPD_ONE: begin
          strb.wrInput = chanSel;
          strb.updDac  = chanSel;
        end
        CMD_POWER:      strb.pdLoad    = 1'b1;
        CMD_CLR_CODE:   strb.clrLoad   = 1'b1;
        CMD_MASK:       strb.maskLoad  = 1'b1;
        CMD_RESET:      strb.softReset = 1'b1;
        default:        strb.data      = '0;
      endcase
    end
  end
endmodule

// File: rtl/qdacRegs.sv
module qdacRegs
  import qdacPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strb,
  output logic [CH_COUNT*CODE_BITS-1:0] dacCodes,
  output logic [CH_COUNT-1:0]           powerDown,
  output logic [CODE_BITS-1:0]          clearCode
);
  logic [CODE_BITS-1:0] inReg  [CH_COUNT];
  logic [CODE_BITS-1:0] dacReg [CH_COUNT];
  logic [CH_COUNT-1:0]  pdReg;
  logic [CH_COUNT-1:0]  maskReg;
  logic [1:0]           clrSel;

  always_comb begin
    case (clrSel)
      2'b01:   clearCode = {1'b1, {(CODE_BITS-1){1'b0}}};
      2'b10:   clearCode = '1;
      default: clearCode = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdReg   <= '0;
      maskReg <= '0;
      clrSel  <= '0;
    end else if (strb.softReset) begin
      pdReg   <= '0;
      maskReg <= '0;
      clrSel  <= '0;
    end else begin
      if (strb.clrLoad && strb.data[1:0] != 2'b11)
        clrSel <= strb.data[1:0];
      if (strb.maskLoad)
        maskReg <= strb.data[CH_COUNT-1:0];
      if (strb.pdLoad) begin
        for (int i = 0; i < CH_COUNT; i++)
          if (strb.data[i]) pdReg[i] <= strb.data[CH_COUNT];
      end
    end
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    logic applyNow;
    assign applyNow = strb.updDac[c]
                    | (strb.wrInput[c] & maskReg[c])
                    | (strb.hwUpdate & ~maskReg[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg[c]  <= '0;
        dacReg[c] <= '0;
      end else if (strb.softReset) begin
        inReg[c]  <= '0;
        dacReg[c] <= '0;
      end else begin
        if (strb.wrInput[c])
          inReg[c] <= strb.data;
        if (strb.hwClear)
          dacReg[c] <= clearCode;
        else if (applyNow)
          dacReg[c] <= strb.wrInput[c] ? strb.data : inReg[c];
      end
    end

    assign dacCodes[c*CODE_BITS +: CODE_BITS] = dacReg[c];
  end

  assign powerDown = pdReg;
endmodule

// File: rtl/qdacFrontEnd.sv
module qdacFrontEnd
  import qdacPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameSyncN,
  input  logic                          serialClk,
  input  logic                          serialDin,
  input  logic                          updateN,
  input  logic                          clearN,
  output logic [CH_COUNT*CODE_BITS-1:0] dacCodes,
  output logic [CH_COUNT-1:0]           powerDown
);
  strobeT               strb;
  logic [CODE_BITS-1:0] clearCode;

  qdacLink #(.SYNC_STAGES(2)) u_link (
    .clk        (clk),
    .rstN       (rstN),
    .frameSyncN (frameSyncN),
    .serialClk  (serialClk),
    .serialDin  (serialDin),
    .updateN    (updateN),
    .clearN     (clearN),
    .strb       (strb)
  );

  qdacRegs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dacCodes  (dacCodes),
    .powerDown (powerDown),
    .clearCode (clearCode)
  );
endmodule

// File: rtl/qdacFrontEndChk.sv
module qdacFrontEndChk
  import qdacPkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input strobeT                        strb,
  input logic [CH_COUNT*CODE_BITS-1:0] dacCodes,
  input logic [CH_COUNT-1:0]           powerDown,
  input logic [CODE_BITS-1:0]          clearCode
);
  logic [CH_COUNT*CODE_BITS-1:0] clearFill;
  assign clearFill = {CH_COUNT{clearCode}};

  // R1
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({(|strb.wrInput) | (|strb.updDac), strb.pdLoad, strb.clrLoad,
              strb.maskLoad, strb.softReset}));

  // R2 R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(dacCodes) && $stable(powerDown)));

  // R8
  power_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pdLoad && !strb.softReset) |=> $stable(powerDown));

  // R9
  clear_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hwClear && !strb.softReset) |=> (dacCodes == $past(clearFill)));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.softReset |=> (dacCodes == '0 && powerDown == '0 && clearCode == '0));
endmodule

bind qdacFrontEnd qdacFrontEndChk u_qdacFrontEndChk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .dacCodes  (dacCodes),
  .powerDown (powerDown),
  .clearCode (clearCode)
);

// File: tb/qdacFrontEnd_bench.sv
module qdacFrontEnd_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSyncN = 1'b1;
  logic serialClk = 1'b1;
  logic serialDin = 1'b0;
  logic updateN = 1'b1;
  logic clearN = 1'b1;
  wire [63:0] dacCodes;
  wire [3:0]  powerDown;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  logic [15:0] expIn  [4];
  logic [15:0] expDac [4];
  logic [3:0]  expPd;
  logic [3:0]  expMask;
  logic [1:0]  expSel;

  always #2 clk = ~clk;

  qdacFrontEnd u_qdacFrontEnd (
    .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .serialClk(serialClk),
    .serialDin(serialDin), .updateN(updateN), .clearN(clearN),
    .dacCodes(dacCodes), .powerDown(powerDown)
  );

  function automatic logic [15:0] clrVal(input logic [1:0] s);
    case (s)
      2'b01:   return 16'h8000;
      2'b10:   return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin expIn[i] = '0; expDac[i] = '0; end
    expPd = '0; expMask = '0; expSel = '0;
  endtask

  task automatic modelFrame(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    logic [3:0] sel;
    sel = (a == 4'hF) ? 4'hF : (a < 4) ? 4'(1 << a) : 4'h0;
    case (c)
      4'h0: for (int i = 0; i < 4; i++)
              if (sel[i]) begin expIn[i] = d; if (expMask[i]) expDac[i] = d; end
      4'h1: for (int i = 0; i < 4; i++) if (sel[i]) expDac[i] = expIn[i];
      4'h2: if (sel != 0) begin
              for (int i = 0; i < 4; i++) if (sel[i]) expIn[i] = d;
              for (int i = 0; i < 4; i++) expDac[i] = expIn[i];
            end
      4'h3: for (int i = 0; i < 4; i++)
              if (sel[i]) begin expIn[i] = d; expDac[i] = d; end
      4'h4: for (int i = 0; i < 4; i++) if (d[i]) expPd[i] = d[4];
      4'h5: if (d[1:0] != 2'b11) expSel = d[1:0];
      4'h6: expMask = d[3:0];
      4'h7: modelReset();
      default: ;
    endcase
  endtask

  task automatic sendFrame(input logic [3:0] c, input logic [3:0] a,
                           input logic [15:0] d, input int nEdges);
    logic [31:0] w;
    w = {4'hA, c, a, d, 4'h5};
    @(negedge clk); frameSyncN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nEdges; i++) begin
      serialDin = w[31-i];
      repeat (4) @(negedge clk);
      serialClk = 1'b0;
      repeat (4) @(negedge clk);
      serialClk = 1'b1;
    end
    repeat (4) @(negedge clk);
    frameSyncN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic pulsePin(input bit isClear);
    @(negedge clk);
    if (isClear) clearN = 1'b0; else updateN = 1'b0;
    repeat (6) @(negedge clk);
    clearN = 1'b1; updateN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    bit bad;
    bad = 0;
    for (int i = 0; i < 4; i++) if (dacCodes[i*16 +: 16] !== expDac[i]) bad = 1;
    if (powerDown !== expPd) bad = 1;
    testCount++;
    if (bad) begin
      failCount++;
      $display("FAIL %s: got dac=%h pd=%b expected dac=%h%h%h%h pd=%b", tag,
               dacCodes, powerDown, expDac[3], expDac[2], expDac[1], expDac[0], expPd);
    end
  endtask

  function automatic string tagFor(input logic [3:0] c, input logic [3:0] a);
    if (c <= 4'h3 && a >= 4'h4 && a <= 4'hE) return "R7 bad address";
    case (c)
      4'h0: return "R3 stage";
      4'h1: return "R4 apply";
      4'h2: return "R5 stage+apply all";
      4'h3: return "R6 stage+apply one";
      4'h4: return "R8 power";
      4'h5: return "R9 clear select";
      4'h6: return "R10 mask";
      4'h7: return "R11 soft reset";
      default: return "R7 reserved";
    endcase
  endfunction

  initial begin
    modelReset();
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R11 reset state");

    // R1 R3 R4: stage all then apply all
    sendFrame(4'h0, 4'hF, 16'h1234, 32); modelFrame(4'h0, 4'hF, 16'h1234);
    checkAll("R3 staged only");
    sendFrame(4'h1, 4'hF, 16'h0000, 32); modelFrame(4'h1, 4'hF, 16'h0000);
    checkAll("R4 apply broadcast");

    // R2: partial frame dropped
    sendFrame(4'h3, 4'hF, 16'hBEEF, 31);
    checkAll("R2 partial frame");
    sendFrame(4'h1, 4'hF, 16'h0000, 32); modelFrame(4'h1, 4'hF, 16'h0000);
    checkAll("R2 staging untouched");

    // R10: mask and update pin
    sendFrame(4'h6, 4'h0, 16'h0005, 32); modelFrame(4'h6, 4'h0, 16'h0005);
    for (int i = 0; i < 4; i++) begin
      sendFrame(4'h0, 4'(i), 16'(16'h2000 + i * 16'h0111), 32);
      modelFrame(4'h0, 4'(i), 16'(16'h2000 + i * 16'h0111));
    end
    checkAll("R10 masked channels apply at once");
    pulsePin(1'b0);
    for (int i = 0; i < 4; i++) if (!expMask[i]) expDac[i] = expIn[i];
    checkAll("R10 update pin");

    // R8: power flags keep codes
    sendFrame(4'h4, 4'h7, 16'h001A, 32); modelFrame(4'h4, 4'h7, 16'h001A);
    checkAll("R8 power down 1,3");

    // R9: clear pin with selected codes
    sendFrame(4'h5, 4'h0, 16'h0001, 32); modelFrame(4'h5, 4'h0, 16'h0001);
    sendFrame(4'h5, 4'h0, 16'h0003, 32); modelFrame(4'h5, 4'h0, 16'h0003);
    pulsePin(1'b1);
    for (int i = 0; i < 4; i++) expDac[i] = clrVal(expSel);
    checkAll("R9 clear mid-scale");
    sendFrame(4'h5, 4'h0, 16'h0002, 32); modelFrame(4'h5, 4'h0, 16'h0002);
    pulsePin(1'b1);
    for (int i = 0; i < 4; i++) expDac[i] = clrVal(expSel);
    checkAll("R9 clear full-scale");
    sendFrame(4'h1, 4'hF, 16'h0000, 32); modelFrame(4'h1, 4'hF, 16'h0000);
    checkAll("R9 staging kept");

    // near-exhaustive sweep of command x address
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 16; k++) begin
        logic [3:0]  c;
        logic [15:0] d;
        c = 4'((k + 5 * a) & 15);
        d = 16'((int'(c) * 4099) ^ (a * 257) ^ (k * 613));
        sendFrame(c, 4'(a), d, 32);
        modelFrame(c, 4'(a), d);
        checkAll(tagFor(c, 4'(a)));
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule